// File: doc/BRIEF.md
# BCD Year Leap-Year Detector

This block takes a calendar year as four packed-decimal digits: thousands, hundreds, tens and ones, four bits each. It reports whether that year is a leap year under the Gregorian rules. It never converts the year to binary. Each divisibility test is decided from a few bits of two digits, so the whole result is a shallow gate network with no arithmetic.

The block brings out three intermediate results: divisible by 4, by 100 and by 400. It also raises a flag when any digit holds a value that is not a decimal digit (10 to 15). A malformed year never reports as a leap year. The block is intended for years after the 1582 calendar reform. It is purely combinational, so it can sit in a date path without adding latency.

Top module: `bcd_leap_detect`

## Requirements
- R1: `div_by4` is 1 for a valid year exactly when either of two cases holds. In the first case, bit 0 of the tens digit is 0 and the ones digit is 0, 4 or 8. In the second case, bit 0 of the tens digit is 1 and the ones digit is 2 or 6.
- R2: `div_by100` is 1 exactly when all eight bits of the tens and ones digits are 0.
- R3: `div_by400` is 1 exactly when `div_by100` is 1 and the R1 rule also holds with bit 0 of the thousands digit in place of the tens bit and the hundreds digit in place of the ones digit.
- R4: For a valid year, `leap_year` equals (`div_by4` and not `div_by100`) or `div_by400`.
- R5: `bad_digit` is 1 whenever any of the four digits holds a value from 10 to 15, in any position, and 0 otherwise.
- R6: `leap_year` is 0 whenever `bad_digit` is 1.
- R7: For every valid BCD year from 1583 to 9999, `leap_year` is 1 exactly when the year is a multiple of 400, or a multiple of 4 that is not a multiple of 100.
- R8: All outputs depend only on the current digit inputs. They take their new values within the same cycle in which the inputs change, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| yr_thou | input | 4 | Thousands digit of the year |
| yr_hund | input | 4 | Hundreds digit of the year |
| yr_tens | input | 4 | Tens digit of the year |
| yr_ones | input | 4 | Ones digit of the year |
| div_by4 | output | 1 | Year is a multiple of 4 |
| div_by100 | output | 1 | Year is a multiple of 100 |
| div_by400 | output | 1 | Year is a multiple of 400 |
| leap_year | output | 1 | Year is a Gregorian leap year; 0 on a malformed digit |
| bad_digit | output | 1 | Some digit holds a value above 9 |

## Verification
Every result is due zero cycles after its stimulus, because the block holds no state. The bench drives all four digits in one assignment just after a rising clock edge. It samples the outputs half a period later, well before the next edge, so each check sees only the current year. The same timing applies to the full sweep of valid years and to the malformed-digit and century cases.

// File: rtl/bcd_leap_detect.sv
module bcd_leap_detect (
  input  logic [3:0] yr_thou,
  input  logic [3:0] yr_hund,
  input  logic [3:0] yr_tens,
  input  logic [3:0] yr_ones,
  output logic       div_by4,
  output logic       div_by100,
  output logic       div_by400,
  output logic       leap_year,
  output logic       bad_digit
);

  // Two-digit multiple-of-4 rule: an even upper digit needs the lower digit in {0,4,8},
  // an odd upper digit needs it in {2,6}. Valid digits make bit 1 and bit 0 enough.
  function automatic logic quad_rule(input logic upper_odd, input logic [3:0] lower);
    return upper_odd ? (lower[1] & ~lower[0]) : (~lower[1] & ~lower[0]);
  endfunction

  function automatic logic over_nine(input logic [3:0] d);
    return d[3] & (d[2] | d[1]);
  endfunction

  logic low_pair_zero;

  assign low_pair_zero = ~|{yr_tens, yr_ones};
  assign bad_digit     = over_nine(yr_thou) | over_nine(yr_hund)
                       | over_nine(yr_tens) | over_nine(yr_ones);

  assign div_by4   = quad_rule(yr_tens[0], yr_ones);
  assign div_by100 = low_pair_zero;
  assign div_by400 = low_pair_zero & quad_rule(yr_thou[0], yr_hund);
  assign leap_year = ~bad_digit & ((div_by4 & ~div_by100) | div_by400);

  always_comb begin
    a_r1_div4_even_ones: assert (bad_digit || !div_by4 || !yr_ones[0]);
    a_r2_century_implies_div4: assert (!div_by100 || div_by4);
    a_r3_div400_needs_div100: assert (!div_by400 || div_by100);
    a_r4_leap_needs_div4: assert (!leap_year || div_by4);
    a_r6_bad_blocks_leap: assert (!(bad_digit && leap_year));
  end

endmodule

// File: tb/bcd_leap_detect_tb.sv
module bcd_leap_detect_tb;

  logic       clk = 1'b0;
  logic [3:0] th, hu, te, on;
  logic       d4, d100, d400, leap, bad;
  int         checks = 0;
  int         failures = 0;
  int         cycles = 0;

  always #4 clk = ~clk;

  bcd_leap_detect u_dut (
    .yr_thou(th), .yr_hund(hu), .yr_tens(te), .yr_ones(on),
    .div_by4(d4), .div_by100(d100), .div_by400(d400),
    .leap_year(leap), .bad_digit(bad)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (year %0d%0d%0d%0d)", req, what, got, exp, th, hu, te, on);
    end
  endtask

  task automatic apply_year(input int y);
    @(posedge clk);
    #1;
    {th, hu, te, on} = {4'((y / 1000) % 10), 4'((y / 100) % 10), 4'((y / 10) % 10), 4'(y % 10)};
    #3;
  endtask

  task automatic check_valid(input int y);
    apply_year(y);
    check("R1", "div_by4", int'(d4), int'(y % 4 == 0));
    check("R2", "div_by100", int'(d100), int'(y % 100 == 0));
    check("R3", "div_by400", int'(d400), int'(y % 400 == 0));
    check("R7", "leap_year", int'(leap), int'((y % 4 == 0 && y % 100 != 0) || y % 400 == 0));
    check("R5", "bad_digit", int'(bad), 0);
  endtask

  task automatic test_zero_year;
    check_valid(0);
    check("R4", "leap at 0000", int'(leap), 1);
  endtask

  task automatic test_centuries;
    int yrs[8] = '{1600, 1700, 1800, 1900, 2000, 2100, 2400, 9600};
    foreach (yrs[i]) begin
      check_valid(yrs[i]);
      check("R4", "century leap", int'(leap), int'(yrs[i] % 400 == 0));
    end
  endtask

  task automatic test_sweep;
    for (int y = 1583; y <= 9999; y++) check_valid(y);
  endtask

  task automatic test_bad_digits;
    for (int pos = 0; pos < 4; pos++) begin
      for (int v = 10; v <= 15; v++) begin
        @(posedge clk);
        #1;
        {th, hu, te, on} = 16'h2000;
        case (pos)
          0: on = 4'(v);
          1: te = 4'(v);
          2: hu = 4'(v);
          default: th = 4'(v);
        endcase
        #3;
        check("R5", "bad_digit set", int'(bad), 1);
        check("R6", "leap forced low", int'(leap), 0);
      end
    end
  endtask

  task automatic test_same_cycle;
    apply_year(2023);
    check("R8", "leap 2023", int'(leap), 0);
    @(posedge clk);
    #1;
    {th, hu, te, on} = 16'h2024;
    #1;
    check("R8", "leap 2024 same cycle", int'(leap), 1);
    check("R4", "div_by4 2024", int'(d4), 1);
  endtask

  initial begin
    {th, hu, te, on} = 16'h0000;
    #2;
    test_zero_year();
    test_centuries();
    test_bad_digits();
    test_same_cycle();
    test_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule